// File: doc/BRIEF.md
# Two-Stage Integer Execute Pipeline

This block is the integer execute section of a small in-order core. Decoded operations arrive with an opcode, two operands, a destination tag and a write-enable. Most of them finish in the first stage. The first-stage register is the only place a following operation can take a bypass result from. The second stage is the writeback point. Bit-counting operations and accesses to the slow special registers finish there, so for these the first stage shows no bypass result.

Multiply, divide and modulo keep the first stage occupied for a fixed number of cycles. During that time the block raises `busy_o`, ignores new input and sends empty slots down the pipe. The carry and overflow status seen by the next operation is the value the unit wrote most recently. After a flush, the status comes from the committed-state input until the unit writes a new value.

Top module: `exec2_pipe`

## Requirements
- R1: Opcodes ADD=0, SUB=1, AND=2, OR=3, XOR=4 and ADDC=5 are accepted when `in_valid_i` is high, `busy_o` is low and `flush_i` is low. The result appears on the `fwd_*` outputs in the cycle after acceptance and on the `wb_*` outputs one cycle later.
- R2: ADD, SUB and ADDC write the status pair {overflow, carry} (bit 1 = signed overflow, bit 0 = carry out; for SUB the carry is the carry out of a + ~b + 1). From the cycle after acceptance, `st_fwd_o` shows the value written.
- R3: ADDC adds bit 0 of `st_fwd_o`, as seen in its acceptance cycle, to the sum of its operands.
- R4: CLZ=6, CTZ=7 and POPC=8 leave `fwd_valid_o` low in the cycle after acceptance. The count appears on `wb_data_o` two cycles after acceptance. A zero operand gives XLEN for CLZ and CTZ.
- R5: MTS=10 writes operand a into slow register number b[0] when it passes into stage 2. MFS=9 returns slow register b[0] on `wb_data_o` two cycles after acceptance. An MFS accepted in the cycle after an MTS sees the new value. The slow registers reset to zero.
- R6: MUL=11 holds `busy_o` high for exactly MUL_CYC cycles (4 by default), and DIV=12 and MOD=13 for exactly DIV_CYC cycles (8 by default). The low half of the product, the unsigned quotient or the unsigned remainder appears on `fwd_*` in the first cycle with `busy_o` low. A zero divisor gives all ones for DIV and operand a for MOD.
- R7: While `busy_o` is high, input is not accepted and `fwd_valid_o` is low, so stage 2 receives empty slots.
- R8: A flush clears `fwd_valid_o`, `wb_valid_o` and `busy_o` in the next cycle, and it aborts a multi-cycle operation without producing a result. It also suppresses a pending slow-register write, and `st_fwd_o` follows `st_commit_i` until the next status write.
- R9: The destination tag and the write-enable travel with their result through both stages.
- R10: After reset, `fwd_valid_o`, `wb_valid_o` and `busy_o` are low and `st_fwd_o` equals `st_commit_i`.
- R11: A valid first-stage result that is not flushed moves unchanged (data, tag) to the writeback outputs in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush_i | input | 1 | Discard all work in flight |
| in_valid_i | input | 1 | Operation present |
| in_op_i | input | 4 | Opcode |
| in_a_i | input | XLEN | Operand a |
| in_b_i | input | XLEN | Operand b |
| in_tag_i | input | TAG_W | Destination tag |
| in_we_i | input | 1 | Destination write-enable |
| st_commit_i | input | 2 | Committed {overflow, carry} |
| busy_o | output | 1 | Multi-cycle operation in progress |
| fwd_valid_o | output | 1 | Stage-1 bypass result valid |
| fwd_tag_o | output | TAG_W | Stage-1 tag |
| fwd_we_o | output | 1 | Stage-1 write-enable |
| fwd_data_o | output | XLEN | Stage-1 bypass result |
| wb_valid_o | output | 1 | Writeback result valid |
| wb_tag_o | output | TAG_W | Writeback tag |
| wb_we_o | output | 1 | Writeback write-enable |
| wb_data_o | output | XLEN | Writeback result |
| st_fwd_o | output | 2 | Forwarded {overflow, carry} |

## Verification
Two events can meet in one cycle: a flush and the last busy cycle of a divide, and a flush and a freshly written status value. The bench raises the flush exactly when the busy count reaches its final cycle. It checks that no quotient appears and that busy drops. In the second case it flushes right after an ADD has set the status, then checks that the forwarded status falls back to the committed input and that a later ADDC adds the committed carry. A flush during a slow-register write is judged by reading that register back afterwards.

// File: rtl/exec2_pkg.sv
// Package: opcode encoding and classification helpers shared by the
// execute pipeline. Assumes 4-bit opcodes; unused codes behave as NOP.
package exec2_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_ADDC = 4'd5,
        OP_CLZ  = 4'd6,
        OP_CTZ  = 4'd7,
        OP_POPC = 4'd8,
        OP_MFS  = 4'd9,
        OP_MTS  = 4'd10,
        OP_MUL  = 4'd11,
        OP_DIV  = 4'd12,
        OP_MOD  = 4'd13,
        OP_NOP  = 4'd15
    } exop_e;

    // Operations whose result is finished in stage 2
    function automatic logic is_late(exop_e op);
        return (op == OP_CLZ) || (op == OP_CTZ) || (op == OP_POPC) ||
               (op == OP_MFS) || (op == OP_MTS);
    endfunction

    // Operations that stall stage 1 for several cycles
    function automatic logic is_md(exop_e op);
        return (op == OP_MUL) || (op == OP_DIV) || (op == OP_MOD);
    endfunction

endpackage

// File: rtl/exec2_alu.sv
// Stage-1 combinational datapath. Finishes the single-cycle arithmetic and
// logic operations and produces the {overflow, carry} status update.
// For late operations it prepares the operand for the stage-2 counter
// (bit-reversed for trailing-zero count). Assumes XLEN >= 2.
module exec2_alu
    import exec2_pkg::*;
#(
    parameter int XLEN = 16
) (
    input  exop_e             op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic              cin,
    output logic [XLEN-1:0]   res,
    output logic              st_we,
    output logic [1:0]        st_new
);

    localparam int MSB = XLEN - 1;

    logic [XLEN:0]   ext;
    logic [XLEN-1:0] rev;

    // Bit reversal of operand a, used to turn trailing into leading zeros
    always_comb begin
        for (int i = 0; i < XLEN; i++) rev[i] = a[MSB-i];
    end

    // Result and status selection per opcode
    always_comb begin
        ext    = '0;
        res    = '0;
        st_we  = 1'b0;
        st_new = 2'b00;
        case (op)
            OP_ADD, OP_ADDC: begin
                ext    = {1'b0, a} + {1'b0, b} + {{XLEN{1'b0}}, (op == OP_ADDC) ? cin : 1'b0};
                res    = ext[MSB:0];
                st_we  = 1'b1;
                st_new = {(a[MSB] == b[MSB]) && (ext[MSB] != a[MSB]), ext[XLEN]};
            end
            OP_SUB: begin
                ext    = {1'b0, a} + {1'b0, ~b} + {{XLEN{1'b0}}, 1'b1};
                res    = ext[MSB:0];
                st_we  = 1'b1;
                st_new = {(a[MSB] != b[MSB]) && (ext[MSB] != a[MSB]), ext[XLEN]};
            end
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CTZ:  res = rev;
            OP_CLZ, OP_POPC, OP_MFS, OP_MTS: res = a;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/exec2_mdiv.sv
// Multi-cycle multiply/divide unit owned by stage 1. A start loads a
// fixed countdown (MUL_CYC or DIV_CYC); busy stays high while the count
// is non-zero and done marks the final busy cycle. Unsigned divide; a zero
// divisor yields all ones (quotient) or the dividend (remainder).
// Assumes start is only raised while idle.
module exec2_mdiv
    import exec2_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int TAG_W   = 5,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              start,
    input  exop_e             op,
    input  logic [XLEN-1:0]   a,
    input  logic [XLEN-1:0]   b,
    input  logic [TAG_W-1:0]  tag,
    input  logic              we,
    output logic              busy,
    output logic              done,
    output logic [XLEN-1:0]   res,
    output logic [TAG_W-1:0]  res_tag,
    output logic              res_we
);

    localparam int MAXC = (MUL_CYC > DIV_CYC) ? MUL_CYC : DIV_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0]     cnt;
    logic [XLEN-1:0]   ra, rb;
    exop_e             rop;
    logic [2*XLEN-1:0] prod;

    // Countdown and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            ra      <= '0;
            rb      <= '0;
            rop     <= OP_NOP;
            res_tag <= '0;
            res_we  <= 1'b0;
        end else if (flush) begin
            cnt <= '0;
        end else if (start) begin
            cnt     <= (op == OP_MUL) ? CW'(MUL_CYC) : CW'(DIV_CYC);
            ra      <= a;
            rb      <= b;
            rop     <= op;
            res_tag <= tag;
            res_we  <= we;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));
    assign prod = {{XLEN{1'b0}}, ra} * {{XLEN{1'b0}}, rb};

    // Final result from the held operands
    always_comb begin
        case (rop)
            OP_MUL:  res = prod[XLEN-1:0];
            OP_DIV:  res = (rb == '0) ? '1 : ra / rb;
            OP_MOD:  res = (rb == '0) ? ra : ra % rb;
            default: res = '0;
        endcase
    end

    // R7: a new multi-cycle operation only starts when the unit is idle
    p_start_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

    // R6: the countdown never exceeds the longest configured latency
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt <= CW'(MAXC)));

endmodule

// File: rtl/exec2_stage2.sv
// Stage 2: finishes the bit-count operations (leading-zero count, which also
// serves trailing zeros on a reversed operand, and population count) and
// the slow special-register moves, then presents the writeback result.
// Slow registers are written as the move enters this stage.
module exec2_stage2
    import exec2_pkg::*;
#(
    parameter int XLEN  = 16,
    parameter int TAG_W = 5,
    parameter int NSLOW = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 flush,
    input  logic                 s1_valid,
    input  logic [TAG_W-1:0]     s1_tag,
    input  logic                 s1_we,
    input  exop_e                s1_op,
    input  logic [XLEN-1:0]      s1_data,
    input  logic [((NSLOW > 1) ? $clog2(NSLOW) : 1)-1:0] s1_sel,
    output logic                 wb_valid,
    output logic [TAG_W-1:0]     wb_tag,
    output logic                 wb_we,
    output logic [XLEN-1:0]      wb_data
);

    localparam int SW    = (NSLOW > 1) ? $clog2(NSLOW) : 1;
    localparam int CNT_W = $clog2(XLEN + 1);

    logic [XLEN-1:0]  sreg [NSLOW];
    logic [CNT_W-1:0] lz, pc;
    logic [XLEN-1:0]  fin;
    logic             sel_ok;

    assign sel_ok = (int'(s1_sel) < NSLOW);

    // Leading-zero count and population count of the stage-1 operand
    always_comb begin
        lz = CNT_W'(XLEN);
        pc = '0;
        for (int i = 0; i < XLEN; i++) begin
            if (s1_data[i]) lz = CNT_W'(XLEN - 1 - i);
            pc = pc + CNT_W'(s1_data[i]);
        end
    end

    // Final stage-2 value per opcode
    always_comb begin
        case (s1_op)
            OP_CLZ, OP_CTZ: fin = XLEN'(lz);
            OP_POPC:        fin = XLEN'(pc);
            OP_MFS:         fin = sel_ok ? sreg[s1_sel] : '0;
            default:        fin = s1_data;
        endcase
    end

    // Slow special registers, written by a move entering stage 2
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSLOW; i++) sreg[i] <= '0;
        end else if (s1_valid && !flush && (s1_op == OP_MTS) && sel_ok) begin
            sreg[s1_sel] <= s1_data;
        end
    end

    // Writeback register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
            wb_tag   <= '0;
            wb_we    <= 1'b0;
            wb_data  <= '0;
        end else begin
            wb_valid <= s1_valid && !flush;
            wb_tag   <= s1_tag;
            wb_we    <= s1_we;
            wb_data  <= fin;
        end
    end

    // R5: a slow-register move that is not flushed is visible next cycle
    p_slow_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && !flush && s1_op == OP_MTS && sel_ok)
        |=> (sreg[$past(s1_sel)] == $past(s1_data)));

endmodule

// File: rtl/exec2_pipe.sv
// Top of the two-stage integer execute pipeline. Stage 1 accepts an
// operation when valid, idle and not flushing, finishes single-cycle work
// and owns the multi-cycle unit; stage 2 finishes counts and slow-register
// moves. Only stage 1 offers a bypass. Status {overflow, carry} is forwarded
// from the last value written, or from the committed input after a flush.
module exec2_pipe
    import exec2_pkg::*;
#(
    parameter int XLEN    = 16,
    parameter int TAG_W   = 5,
    parameter int MUL_CYC = 4,
    parameter int DIV_CYC = 8,
    parameter int NSLOW   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              in_valid_i,
    input  logic [3:0]        in_op_i,
    input  logic [XLEN-1:0]   in_a_i,
    input  logic [XLEN-1:0]   in_b_i,
    input  logic [TAG_W-1:0]  in_tag_i,
    input  logic              in_we_i,
    input  logic [1:0]        st_commit_i,
    output logic              busy_o,
    output logic              fwd_valid_o,
    output logic [TAG_W-1:0]  fwd_tag_o,
    output logic              fwd_we_o,
    output logic [XLEN-1:0]   fwd_data_o,
    output logic              wb_valid_o,
    output logic [TAG_W-1:0]  wb_tag_o,
    output logic              wb_we_o,
    output logic [XLEN-1:0]   wb_data_o,
    output logic [1:0]        st_fwd_o
);

    localparam int SW = (NSLOW > 1) ? $clog2(NSLOW) : 1;

    exop_e            op_in;
    logic             accept, md_start;
    logic [XLEN-1:0]  alu_res;
    logic             alu_st_we;
    logic [1:0]       alu_st;
    logic             md_busy, md_done, md_we;
    logic [XLEN-1:0]  md_res;
    logic [TAG_W-1:0] md_tag;

    logic             s1_valid, s1_we;
    logic [TAG_W-1:0] s1_tag;
    exop_e            s1_op;
    logic [XLEN-1:0]  s1_data;
    logic [SW-1:0]    s1_sel;

    logic [1:0]       st_last;
    logic             st_use_last;

    assign op_in    = exop_e'(in_op_i);
    assign accept   = in_valid_i && !md_busy && !flush_i;
    assign md_start = accept && is_md(op_in);
    assign st_fwd_o = st_use_last ? st_last : st_commit_i;

    exec2_alu #(.XLEN(XLEN)) u_alu (
        .op     (op_in),
        .a      (in_a_i),
        .b      (in_b_i),
        .cin    (st_fwd_o[0]),
        .res    (alu_res),
        .st_we  (alu_st_we),
        .st_new (alu_st)
    );

    exec2_mdiv #(.XLEN(XLEN), .TAG_W(TAG_W), .MUL_CYC(MUL_CYC), .DIV_CYC(DIV_CYC)) u_mdiv (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush_i),
        .start   (md_start),
        .op      (op_in),
        .a       (in_a_i),
        .b       (in_b_i),
        .tag     (in_tag_i),
        .we      (in_we_i),
        .busy    (md_busy),
        .done    (md_done),
        .res     (md_res),
        .res_tag (md_tag),
        .res_we  (md_we)
    );

    // Stage-1 register: multi-cycle result, new single-cycle op, or bubble
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_tag   <= '0;
            s1_we    <= 1'b0;
            s1_op    <= OP_NOP;
            s1_data  <= '0;
            s1_sel   <= '0;
        end else if (flush_i) begin
            s1_valid <= 1'b0;
        end else if (md_done) begin
            s1_valid <= 1'b1;
            s1_tag   <= md_tag;
            s1_we    <= md_we;
            s1_op    <= OP_MUL;
            s1_data  <= md_res;
        end else if (accept && !is_md(op_in)) begin
            s1_valid <= 1'b1;
            s1_tag   <= in_tag_i;
            s1_we    <= in_we_i;
            s1_op    <= op_in;
            s1_data  <= alu_res;
            s1_sel   <= in_b_i[SW-1:0];
        end else begin
            s1_valid <= 1'b0;
        end
    end

    // Status forwarding: remember last write, fall back to committed on flush
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_last     <= 2'b00;
            st_use_last <= 1'b0;
        end else if (flush_i) begin
            st_use_last <= 1'b0;
        end else if (accept && alu_st_we) begin
            st_last     <= alu_st;
            st_use_last <= 1'b1;
        end
    end

    exec2_stage2 #(.XLEN(XLEN), .TAG_W(TAG_W), .NSLOW(NSLOW)) u_s2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_i),
        .s1_valid (s1_valid),
        .s1_tag   (s1_tag),
        .s1_we    (s1_we),
        .s1_op    (s1_op),
        .s1_data  (s1_data),
        .s1_sel   (s1_sel),
        .wb_valid (wb_valid_o),
        .wb_tag   (wb_tag_o),
        .wb_we    (wb_we_o),
        .wb_data  (wb_data_o)
    );

    assign busy_o      = md_busy;
    assign fwd_valid_o = s1_valid && !is_late(s1_op);
    assign fwd_tag_o   = s1_tag;
    assign fwd_we_o    = s1_we;
    assign fwd_data_o  = s1_data;

    // R7: no bypass result while the multi-cycle unit holds stage 1
    p_bubble_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !fwd_valid_o);

    // R8: a flush empties both stages and ends any busy period
    p_flush_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (!fwd_valid_o && !wb_valid_o && !busy_o && st_fwd_o == st_commit_i));

    // R6: the result is on the bypass when busy ends without a flush
    p_md_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && !$past(flush_i)) |-> fwd_valid_o);

    // R11: an unflushed bypass result reaches writeback unchanged
    p_wb_follow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid_o && !flush_i) |=>
        (wb_valid_o && wb_data_o == $past(fwd_data_o) && wb_tag_o == $past(fwd_tag_o)));

endmodule

// File: tb/exec2_pipe_test.sv
module exec2_pipe_test;

    localparam int XL   = 8;
    localparam int TW   = 4;
    localparam int MULC = 4;
    localparam int DIVC = 8;

    localparam logic [3:0] ADD = 4'd0, SUB = 4'd1, AND_ = 4'd2, OR_ = 4'd3, XOR_ = 4'd4,
                           ADDC = 4'd5, CLZ = 4'd6, CTZ = 4'd7, POPC = 4'd8,
                           MFS = 4'd9, MTS = 4'd10, MUL = 4'd11, DIV = 4'd12, MOD = 4'd13;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, in_valid = 1'b0, in_we = 1'b0;
    logic [3:0]    in_op = 4'd0;
    logic [XL-1:0] in_a = '0, in_b = '0;
    logic [TW-1:0] in_tag = '0;
    logic [1:0]    st_commit = 2'b10;
    logic          busy, fwd_valid, fwd_we, wb_valid, wb_we;
    logic [TW-1:0] fwd_tag, wb_tag;
    logic [XL-1:0] fwd_data, wb_data;
    logic [1:0]    st_fwd;

    int total = 0, bad = 0;
    logic [1:0] m_last = 2'b00;
    logic       m_use = 1'b0;

    exec2_pipe #(.XLEN(XL), .TAG_W(TW), .MUL_CYC(MULC), .DIV_CYC(DIVC), .NSLOW(2)) uut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush), .in_valid_i(in_valid), .in_op_i(in_op),
        .in_a_i(in_a), .in_b_i(in_b), .in_tag_i(in_tag), .in_we_i(in_we),
        .st_commit_i(st_commit), .busy_o(busy), .fwd_valid_o(fwd_valid), .fwd_tag_o(fwd_tag),
        .fwd_we_o(fwd_we), .fwd_data_o(fwd_data), .wb_valid_o(wb_valid), .wb_tag_o(wb_tag),
        .wb_we_o(wb_we), .wb_data_o(wb_data), .st_fwd_o(st_fwd)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] m_st();
        return m_use ? m_last : st_commit;
    endfunction

    // Returns {ov, carry, result}; status write flag via op kind
    function automatic logic [XL+1:0] model(input logic [3:0] op, input logic [XL-1:0] a,
                                            input logic [XL-1:0] b, input logic cin);
        logic [XL:0] s;
        logic ov;
        s = '0; ov = 1'b0;
        case (op)
            ADD, ADDC: begin
                s  = {1'b0, a} + {1'b0, b} + ((op == ADDC) ? (XL+1)'(cin) : '0);
                ov = (a[XL-1] == b[XL-1]) && (s[XL-1] != a[XL-1]);
            end
            SUB: begin
                s  = {1'b0, a} + {1'b0, ~b} + (XL+1)'(1);
                ov = (a[XL-1] != b[XL-1]) && (s[XL-1] != a[XL-1]);
            end
            AND_: s = {1'b0, a & b};
            OR_:  s = {1'b0, a | b};
            default: s = {1'b0, a ^ b};
        endcase
        return {ov, s};
    endfunction

    task automatic drive(input logic [3:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b,
                         input logic [TW-1:0] tag, input logic we);
        in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_tag = tag; in_we = we;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Single-cycle op: R1 timing, R9 tag/we, R2 status, R3 carry use
    task automatic do_simple(input logic [3:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b,
                             input logic [TW-1:0] tag);
        logic [XL+1:0] m;
        m = model(op, a, b, m_st()[0]);
        drive(op, a, b, tag, tag[0]);
        chk(fwd_valid && fwd_data == m[XL-1:0], "R1 fwd", {fwd_valid, fwd_data}, {1'b1, m[XL-1:0]});
        chk(fwd_tag == tag && fwd_we == tag[0], "R9 fwd tag", {fwd_we, fwd_tag}, {tag[0], tag});
        if (op == ADD || op == SUB || op == ADDC) begin
            m_last = m[XL+1:XL]; m_use = 1'b1;
        end
        chk(st_fwd == m_st(), "R2 status", st_fwd, m_st());
        @(negedge clk);
        chk(wb_valid && wb_data == m[XL-1:0] && wb_tag == tag, "R1 wb",
            {wb_valid, wb_tag, wb_data}, {1'b1, tag, m[XL-1:0]});
    endtask

    task automatic do_late(input logic [3:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b,
                           input logic [XL-1:0] exp, input string req);
        drive(op, a, b, 4'd3, 1'b1);
        chk(!fwd_valid, req, fwd_valid, 0);
        @(negedge clk);
        chk(wb_valid && wb_data == exp && wb_tag == 4'd3 && wb_we, req,
            {wb_valid, wb_data}, {1'b1, exp});
    endtask

    task automatic do_md(input logic [3:0] op, input logic [XL-1:0] a, input logic [XL-1:0] b,
                         input logic [XL-1:0] exp, input int ncyc);
        int nb;
        nb = 0;
        drive(op, a, b, 4'd9, 1'b1);
        while (busy && nb < 50) begin
            nb++;
            chk(!fwd_valid, "R7 bubble", fwd_valid, 0);
            if (nb == 1) begin
                in_valid = 1'b1; in_op = ADD; in_a = 8'h11; in_b = 8'h22; in_tag = 4'd5;
            end else in_valid = 1'b0;
            @(negedge clk);
        end
        chk(nb == ncyc, "R6 busy length", nb, ncyc);
        chk(fwd_valid && fwd_data == exp && fwd_tag == 4'd9, "R6 result", fwd_data, exp);
        @(negedge clk);
        chk(wb_valid && wb_data == exp, "R6 wb", wb_data, exp);
        chk(!fwd_valid, "R7 ignored input", fwd_valid, 0);
        @(negedge clk);
        chk(!wb_valid, "R7 ignored input wb", wb_valid, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [XL-1:0] e;
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk(!fwd_valid && !wb_valid && !busy, "R10 reset", {fwd_valid, wb_valid, busy}, 0);
        chk(st_fwd == st_commit, "R10 status", st_fwd, st_commit);

        // R1/R2/R3 sweep of single-cycle ops
        for (int a = 0; a < 256; a += 15)
            for (int b = 0; b < 256; b += 15)
                for (int op = 0; op < 6; op++)
                    do_simple(4'(op), 8'(a), 8'(b), 4'(a + op));

        // R4 counts, exhaustive
        for (int v = 0; v < 256; v++) begin
            cnt = 0; for (int i = 0; i < XL; i++) cnt += v[i];
            do_late(POPC, 8'(v), 8'd0, 8'(cnt), "R4 popc");
            cnt = XL; for (int i = 0; i < XL; i++) if (v[i]) cnt = XL - 1 - i;
            do_late(CLZ, 8'(v), 8'd0, 8'(cnt), "R4 clz");
            cnt = XL; for (int i = XL - 1; i >= 0; i--) if (v[i]) cnt = i;
            do_late(CTZ, 8'(v), 8'd0, 8'(cnt), "R4 ctz");
        end

        // R5 slow registers: reset zero, write, read, back-to-back
        do_late(MFS, 8'h77, 8'd0, 8'h00, "R5 reset sreg0");
        do_late(MFS, 8'h77, 8'd1, 8'h00, "R5 reset sreg1");
        do_late(MTS, 8'h3C, 8'd0, 8'h3C, "R5 move to");
        do_late(MTS, 8'hA5, 8'd1, 8'hA5, "R5 move to");
        do_late(MFS, 8'h00, 8'd0, 8'h3C, "R5 read sreg0");
        do_late(MFS, 8'h00, 8'd1, 8'hA5, "R5 read sreg1");
        in_valid = 1'b1; in_op = MTS; in_a = 8'h5E; in_b = 8'd1; in_tag = 4'd1;
        @(negedge clk);
        in_op = MFS; in_b = 8'd1; in_tag = 4'd2;
        @(negedge clk);
        in_valid = 1'b0;
        chk(wb_valid && wb_tag == 4'd1, "R5 pipelined mts", wb_tag, 1);
        @(negedge clk);
        chk(wb_valid && wb_tag == 4'd2 && wb_data == 8'h5E, "R5 read after write", wb_data, 8'h5E);

        // R6 multi-cycle operations, including zero divisor
        for (int a = 0; a < 256; a += 37)
            for (int b = 0; b < 256; b += 51) begin
                do_md(MUL, 8'(a), 8'(b), 8'(a * b), MULC);
                do_md(DIV, 8'(a), 8'(b), (b == 0) ? 8'hFF : 8'(a / b), DIVC);
                do_md(MOD, 8'(a), 8'(b), (b == 0) ? 8'(a) : 8'(a % b), DIVC);
            end

        // R3 back-to-back: ADDC consumes the carry written the cycle before
        in_valid = 1'b1; in_op = ADD; in_a = 8'hF0; in_b = 8'h20; in_tag = 4'd6;
        @(negedge clk);
        in_op = ADDC; in_a = 8'h01; in_b = 8'h02; in_tag = 4'd7;
        @(negedge clk);
        in_valid = 1'b0;
        m_last = 2'b01; m_use = 1'b1;
        chk(fwd_valid && fwd_data == 8'h04 && fwd_tag == 4'd7, "R3 back-to-back", fwd_data, 8'h04);
        chk(wb_valid && wb_data == 8'h10 && wb_tag == 4'd6, "R11 pipelined wb", wb_data, 8'h10);

        // R8 flush right after a status write, with input ignored
        st_commit = 2'b01;
        do_simple(ADD, 8'h80, 8'h80, 4'd2);
        drive(ADD, 8'h80, 8'h80, 4'd4, 1'b1);
        flush = 1'b1; in_valid = 1'b1; in_op = XOR_;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0; m_use = 1'b0;
        chk(!fwd_valid && !wb_valid, "R8 flush clears", {fwd_valid, wb_valid}, 0);
        chk(st_fwd == 2'b01, "R8 commit status", st_fwd, 2'b01);
        do_simple(ADDC, 8'h10, 8'h20, 4'd8);
        e = fwd_data;

        // R8 flush suppresses a pending slow-register write
        drive(MTS, 8'h99, 8'd0, 4'd1, 1'b1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!wb_valid, "R8 flushed move", wb_valid, 0);
        do_late(MFS, 8'h00, 8'd0, 8'h3C, "R8 sreg unchanged");

        // R8 flush in the final busy cycle of a divide
        drive(DIV, 8'd200, 8'd7, 4'd3, 1'b1);
        cnt = 1;
        while (cnt < DIVC) begin @(negedge clk); cnt++; end
        chk(busy, "R6 still busy", busy, 1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!busy && !fwd_valid, "R8 abort divide", {busy, fwd_valid}, 0);
        @(negedge clk);
        chk(!wb_valid && !fwd_valid, "R8 no result", {wb_valid, fwd_valid}, 0);

        // R8 flush mid multiply
        drive(MUL, 8'd3, 8'd5, 4'd3, 1'b1);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        chk(!busy, "R8 abort multiply", busy, 0);
        repeat (MULC) begin
            @(negedge clk);
            chk(!fwd_valid && !wb_valid, "R8 multiply silent", {fwd_valid, wb_valid}, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule